// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a physical memory access may proceed. It holds sixteen protection entries. Each entry has a 32-bit address register and an 8-bit configuration byte. Software reaches them through a small register port: a write strobe, an index, write data and a read-data bus with no read latency. Each configuration byte holds read, write and execute permission bits, a two-bit match mode and a lock bit.

A request carries an address, a length of 1 to 8 bytes, an access kind and the current privilege level. The block splits the request into 4-byte sectors and searches the entries from index 0 upward. The first enabled entry that covers any sector decides the outcome. One clock after the request strobe it returns allow or deny. On a deny it also returns the exception cause and the faulting address.

Top module: `pmp_checker`

## Requirements
- R1: After reset, `respValid` is low and every register reads back as zero.
- R2: Register indices 0 to 15 select the address registers of entries 0 to 15. Indices 16 to 19 select the configuration registers. Entry k sits in bits [8*(k%4)+7 : 8*(k%4)] of register 16+k/4. Writes to these indices are read back on `csrRdata`. Indices 20 and above read as zero and ignore writes.
- R3: A configuration write clears bits 5 and 6 of every byte. Writing all ones therefore reads back as 0x9f9f9f9f.
- R4: `respValid` is high in exactly the cycle after each cycle in which `reqValid` is high. The response reflects the request and the registers as they were in the request cycle.
- R5: When every entry has match mode 0, every access is allowed.
- R6: The configuration byte has R at bit 0, W at bit 1, X at bit 2, the match mode at bits 4:3 and the lock bit L at bit 7. Mode 1 (top-of-range) matches a byte address a when (previous entry's address register << 2) <= a < (own address register << 2). For entry 0 the lower bound is 0. The lower bound applies whatever the previous entry's mode.
- R7: Mode 2 matches the single aligned 4-byte word at (address register << 2). Mode 3 matches a naturally aligned region of 8·2^t bytes, where t is the number of trailing ones in the address register.
- R8: Entries are searched from index 0 upward. The lowest-indexed enabled entry that matches any sector decides, even if a higher entry would grant the access.
- R9: The access covers the sectors at addr + 4·j for every 4·j < length. If the deciding entry does not match all of them, the access is denied, in machine mode too.
- R10: Access kind 0 is read, 1 is write and 2 is fetch. A deciding entry allows the access in two cases: privilege 3 (machine) with L clear, or the permission bit for the kind (R, W or X) set. Otherwise the access is denied.
- R11: With at least one entry enabled, an access that no entry matches is allowed only at privilege 3.
- R12: On a deny, `respCause` is 1 for a fetch, 5 for a read and 7 for a write, and `respAddr` is the request address. On an allow both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csrWe | input | 1 | Register write strobe |
| csrAddr | input | 5 | Register index |
| csrWdata | input | 32 | Register write data |
| csrRdata | output | 32 | Read data for `csrAddr`, no read latency |
| reqValid | input | 1 | Access check request strobe |
| reqAddr | input | 32 | Access byte address |
| reqLen | input | 4 | Access length in bytes, 1 to 8 |
| reqKind | input | 2 | 0 read, 1 write, 2 fetch |
| reqPriv | input | 2 | Privilege level, 3 is machine |
| respValid | output | 1 | Response strobe, one cycle after the request |
| respAllow | output | 1 | Access allowed |
| respCause | output | 4 | Exception cause on deny, else 0 |
| respAddr | output | 32 | Faulting address on deny, else 0 |

## Verification
The hardest case to reach is a lower-indexed entry that covers only part of a multi-sector access while a higher entry would grant all of it. To reach it, the stimulus needs an 8-byte access that straddles a region edge, and entries that overlap with different permissions. Directed phases set up each of these layouts: a top-of-range edge at 0x100 crossed by an access at 0xFC, and a large aligned region overlapping a smaller one. A random phase then keeps every region bound and every access address inside the first kilobyte, so that overlaps and straddles happen often. A behavioural model checks each response.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int XLEN        = 32;
  localparam int NUM_ENTRIES = 16;
  localparam int MAX_SECT    = 2;
  localparam int CFG_BYTES   = XLEN / 8;
  localparam int NUM_CFG     = NUM_ENTRIES / CFG_BYTES;
  localparam int CSR_AW      = $clog2(NUM_ENTRIES + NUM_CFG);
  localparam int IDX_W       = $clog2(NUM_ENTRIES);
  localparam int CFG_IW      = $clog2(NUM_CFG);
  localparam int LEN_W       = $clog2(MAX_SECT * 4 + 1);
  localparam int CAUSE_W     = 4;

  localparam logic [7:0] CFG_KEEP = 8'h9f;
  localparam logic [1:0] PRIV_MACHINE = 2'd3;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_TOR   = 2'd1;
  localparam logic [1:0] MODE_WORD  = 2'd2;
  localparam logic [1:0] MODE_POW2  = 2'd3;

  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 4'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 4'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE = 4'd7;

  typedef struct packed {
    logic              capture;
    logic              addrWe;
    logic              cfgWe;
    logic              rdAddr;
    logic              rdCfg;
    logic [IDX_W-1:0]  entryIdx;
    logic [CFG_IW-1:0] cfgIdx;
  } pmpStrobe_t;
endpackage

// File: rtl/pmp_match.sv
module pmp_match
  import pmp_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic [XLEN-1:0]  entryAddr,
  input  logic [XLEN-1:0]  prevTop,
  input  logic [XLEN-1:0]  reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  output logic             anyHit,
  output logic             allHit
);
  logic [XLEN-1:0] top;
  logic [XLEN-1:0] seed;
  logic [XLEN-1:0] run;
  logic [XLEN-1:0] mask;
  logic [MAX_SECT-1:0] sectActive;
  logic [MAX_SECT-1:0] sectHit;

  assign top  = {entryAddr[XLEN-3:0], 2'b00};
  assign seed = {entryAddr[XLEN-2:0], (mode != MODE_WORD)};
  assign run  = seed & ~(seed + XLEN'(1));
  assign mask = {~run[XLEN-3:0], 2'b00};

  for (genvar s = 0; s < MAX_SECT; s++) begin : g_sect
    logic [XLEN-1:0] cur;
    logic torHit;
    logic alignHit;
    assign cur      = reqAddr + XLEN'(s * 4);
    assign torHit   = (cur >= prevTop) && (cur < top);
    assign alignHit = (cur & mask) == (top & mask);
    assign sectActive[s] = LEN_W'(s * 4) < reqLen;
    always_comb begin
      case (mode)
        MODE_TOR:             sectHit[s] = torHit;
        MODE_WORD, MODE_POW2: sectHit[s] = alignHit;
        default:              sectHit[s] = 1'b0;
      endcase
    end
  end

  assign anyHit = |(sectActive & sectHit);
  assign allHit = &(~sectActive | sectHit);
endmodule

// File: rtl/pmp_ctrl.sv
module pmp_ctrl
  import pmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              csrWe,
  input  logic [CSR_AW-1:0] csrAddr,
  output pmpStrobe_t        strobe,
  output logic              respValid
);
  logic inAddrRange;
  logic inCfgRange;

  assign inAddrRange = csrAddr < CSR_AW'(NUM_ENTRIES);
  assign inCfgRange  = !inAddrRange && (csrAddr < CSR_AW'(NUM_ENTRIES + NUM_CFG));

  always_comb begin
    strobe.capture  = reqValid;
    strobe.addrWe   = csrWe && inAddrRange;
    strobe.cfgWe    = csrWe && inCfgRange;
    strobe.rdAddr   = inAddrRange;
    strobe.rdCfg    = inCfgRange;
    strobe.entryIdx = IDX_W'(csrAddr);
    strobe.cfgIdx   = CFG_IW'(csrAddr - CSR_AW'(NUM_ENTRIES));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= reqValid;
  end

  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R4
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid); // R4
  AST_WRITE_DECODE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.addrWe && strobe.cfgWe)); // R2
endmodule

// File: rtl/pmp_datapath.sv
module pmp_datapath
  import pmp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  pmpStrobe_t         strobe,
  input  logic [XLEN-1:0]    csrWdata,
  output logic [XLEN-1:0]    csrRdata,
  input  logic [XLEN-1:0]    reqAddr,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [1:0]         reqKind,
  input  logic [1:0]         reqPriv,
  output logic               respAllow,
  output logic [CAUSE_W-1:0] respCause,
  output logic [XLEN-1:0]    respAddr
);
  logic [NUM_ENTRIES-1:0][7:0]      cfgQ;
  logic [NUM_ENTRIES-1:0][XLEN-1:0] addrQ;
  logic [NUM_ENTRIES-1:0]           anyHit;
  logic [NUM_ENTRIES-1:0]           allHit;
  logic [NUM_ENTRIES-1:0]           firstHit;
  logic                             found;
  logic [IDX_W-1:0]                 selIdx;
  logic [7:0]                       selCfg;
  logic                             anyActive;
  logic                             permOk;
  logic                             allowNow;
  logic [CAUSE_W-1:0]               denyCause;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      addrQ <= '0;
    end else begin
      if (strobe.addrWe) addrQ[strobe.entryIdx] <= csrWdata;
      if (strobe.cfgWe) begin
        for (int b = 0; b < CFG_BYTES; b++)
          cfgQ[int'(strobe.cfgIdx) * CFG_BYTES + b] <= csrWdata[8*b +: 8] & CFG_KEEP;
      end
    end
  end

  always_comb begin
    csrRdata = '0;
    if (strobe.rdAddr)     csrRdata = addrQ[strobe.entryIdx];
    else if (strobe.rdCfg) csrRdata = cfgQ[int'(strobe.cfgIdx) * CFG_BYTES +: CFG_BYTES];
  end

  always_comb begin
    anyActive = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      anyActive = anyActive | (cfgQ[i][4:3] != MODE_OFF);
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic [XLEN-1:0] prevTop;
    if (i == 0) begin : g_first
      assign prevTop = '0;
    end else begin : g_rest
      assign prevTop = {addrQ[i-1][XLEN-3:0], 2'b00};
    end
    pmp_match u_match (
      .mode      (cfgQ[i][4:3]),
      .entryAddr (addrQ[i]),
      .prevTop   (prevTop),
      .reqAddr   (reqAddr),
      .reqLen    (reqLen),
      .anyHit    (anyHit[i]),
      .allHit    (allHit[i])
    );
  end

  always_comb begin
    found    = 1'b0;
    selIdx   = '0;
    firstHit = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && anyHit[i]) begin
        found       = 1'b1;
        selIdx      = IDX_W'(i);
        firstHit[i] = 1'b1;
      end
    end
  end

  assign selCfg = cfgQ[selIdx];

  always_comb begin
    case (reqKind)
      KIND_WRITE: begin permOk = selCfg[1]; denyCause = CAUSE_STORE; end
      KIND_FETCH: begin permOk = selCfg[2]; denyCause = CAUSE_FETCH; end
      default:    begin permOk = selCfg[0]; denyCause = CAUSE_LOAD;  end
    endcase
  end

  always_comb begin
    if (!anyActive)  allowNow = 1'b1;
    else if (found)  allowNow = allHit[selIdx] &&
                                (((reqPriv == PRIV_MACHINE) && !selCfg[7]) || permOk);
    else             allowNow = reqPriv == PRIV_MACHINE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respAllow <= 1'b0;
      respCause <= '0;
      respAddr  <= '0;
    end else if (strobe.capture) begin
      respAllow <= allowNow;
      respCause <= allowNow ? '0 : denyCause;
      respAddr  <= allowNow ? '0 : reqAddr;
    end
  end

  AST_FIRST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(firstHit)); // R8
  AST_IDLE_ALLOWS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && !anyActive |=> respAllow); // R5
  AST_DENY_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.capture) && !respAllow |->
      (respCause == CAUSE_FETCH || respCause == CAUSE_LOAD || respCause == CAUSE_STORE)); // R12
  AST_ALLOW_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    respAllow |-> (respCause == '0 && respAddr == '0)); // R12
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (respAllow || respAddr == $past(reqAddr))); // R12
  AST_PARTIAL_DENIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && found && !allHit[selIdx] |=> !respAllow); // R9
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               csrWe,
  input  logic [CSR_AW-1:0]  csrAddr,
  input  logic [XLEN-1:0]    csrWdata,
  output logic [XLEN-1:0]    csrRdata,
  input  logic               reqValid,
  input  logic [XLEN-1:0]    reqAddr,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [1:0]         reqKind,
  input  logic [1:0]         reqPriv,
  output logic               respValid,
  output logic               respAllow,
  output logic [CAUSE_W-1:0] respCause,
  output logic [XLEN-1:0]    respAddr
);
  pmpStrobe_t strobe;

  pmp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .csrWe     (csrWe),
    .csrAddr   (csrAddr),
    .strobe    (strobe),
    .respValid (respValid)
  );

  pmp_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .csrWdata  (csrWdata),
    .csrRdata  (csrRdata),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .reqKind   (reqKind),
    .reqPriv   (reqPriv),
    .respAllow (respAllow),
    .respCause (respCause),
    .respAddr  (respAddr)
  );
endmodule

// File: tb/sim_pmp_checker.sv
`timescale 1ns/1ps
module sim_pmp_checker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWe = 1'b0;
  logic [4:0]  csrAddr = '0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqLen = 4'd4;
  logic [1:0]  reqKind = '0;
  logic [1:0]  reqPriv = '0;
  logic        respValid;
  logic        respAllow;
  logic [3:0]  respCause;
  logic [31:0] respAddr;

  int    tests = 0;
  int    fails = 0;
  string curTag = "R1";

  bit [31:0] mAddr[16];
  bit [7:0]  mCfg[16];
  bit        eValid = 0;
  bit        eAllow = 0;
  int        eCause = 0;
  bit [31:0] eAddr = 0;

  always #4 clk = ~clk;

  pmp_checker u0 (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrAddr(csrAddr), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .reqValid(reqValid), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqKind(reqKind), .reqPriv(reqPriv), .respValid(respValid), .respAllow(respAllow),
    .respCause(respCause), .respAddr(respAddr)
  );

  function automatic bit [31:0] modelRead(input int a);
    if (a < 16) return mAddr[a];
    if (a < 20) return {mCfg[(a-16)*4+3], mCfg[(a-16)*4+2], mCfg[(a-16)*4+1], mCfg[(a-16)*4]};
    return 0;
  endfunction

  function automatic void modelDecide(input longint unsigned a, input int len, input int kind,
                                      input int priv, output bit allow, output int cause);
    bit anyOn = 0;
    bit decided = 0;
    for (int i = 0; i < 16; i++) if (mCfg[i][4:3] != 0) anyOn = 1;
    allow = (priv == 3);
    if (!anyOn) allow = 1;
    else begin
      for (int i = 0; i < 16 && !decided; i++) begin
        int mode = mCfg[i][4:3];
        longint unsigned lo, hi, top, size;
        int hits = 0, n = 0, t = 0;
        bit perm;
        if (mode == 0) continue;
        top = (longint'(mAddr[i]) << 2) & 64'hffff_ffff;
        if (mode == 1) begin
          lo = (i == 0) ? 0 : ((longint'(mAddr[i-1]) << 2) & 64'hffff_ffff);
          hi = top;
        end else begin
          if (mode == 2) size = 4;
          else begin
            while (t < 32 && mAddr[i][t]) t++;
            size = 64'd8 << t;
          end
          lo = top - (top % size);
          hi = lo + size;
        end
        for (int off = 0; off < len; off += 4) begin
          longint unsigned cur = (a + off) & 64'hffff_ffff;
          n++;
          if (cur >= lo && cur < hi) hits++;
        end
        if (hits == 0) continue;
        decided = 1;
        perm = (kind == 1) ? mCfg[i][1] : (kind == 2) ? mCfg[i][2] : mCfg[i][0];
        allow = (hits == n) && ((priv == 3 && !mCfg[i][7]) || perm);
      end
    end
    cause = allow ? 0 : (kind == 2) ? 1 : (kind == 1) ? 7 : 5;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      eValid = 0; eAllow = 0; eCause = 0; eAddr = 0;
      foreach (mAddr[i]) begin mAddr[i] = 0; mCfg[i] = 0; end
    end else begin
      bit al; int ca;
      eValid = reqValid;
      if (reqValid) begin
        modelDecide(reqAddr, reqLen, reqKind, reqPriv, al, ca);
        eAllow = al; eCause = ca; eAddr = al ? 0 : reqAddr;
      end
      if (csrWe) begin
        if (csrAddr < 16) mAddr[csrAddr] = csrWdata;
        else if (csrAddr < 20)
          for (int b = 0; b < 4; b++) mCfg[(csrAddr-16)*4+b] = csrWdata[8*b +: 8] & 8'h9f;
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", curTag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      chk("respValid", {31'b0, respValid}, {31'b0, eValid});
      if (eValid) begin
        chk("respAllow", {31'b0, respAllow}, {31'b0, eAllow});
        chk("respCause", {28'b0, respCause}, eCause);
        chk("respAddr", respAddr, eAddr);
      end
      chk("csrRdata", csrRdata, modelRead(csrAddr));
    end
  end

  task automatic csrW(input int a, input logic [31:0] d);
    csrWe = 1; csrAddr = 5'(a); csrWdata = d;
    @(negedge clk); #1;
    csrWe = 0;
  endtask

  task automatic rd(input int a);
    csrAddr = 5'(a);
    @(negedge clk); #1;
  endtask

  task automatic acc(input logic [31:0] a, input int len, input int kind, input int priv);
    reqValid = 1; reqAddr = a; reqLen = 4'(len); reqKind = 2'(kind); reqPriv = 2'(priv);
    @(negedge clk); #1;
    reqValid = 0;
    @(negedge clk); #1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    curTag = "R1";
    chk("reset respValid", {31'b0, respValid}, 0);
    for (int a = 0; a < 22; a++) rd(a);

    curTag = "R5";
    acc(32'h80, 4, 1, 0);
    acc(32'h1234, 8, 2, 1);

    curTag = "R2";
    for (int a = 0; a < 16; a++) csrW(a, 32'h1000 + a * 32'h11);
    for (int a = 0; a < 21; a++) rd(a);
    csrW(20, 32'hdeadbeef);
    rd(20);
    csrW(17, 32'h00070605);
    rd(17);
    csrW(17, 0);

    curTag = "R3";
    csrW(19, 32'hffffffff);
    rd(19);
    csrW(19, 0);
    rd(19);

    curTag = "R4";
    reqValid = 1; reqAddr = 32'h40; reqKind = 0; reqPriv = 0; reqLen = 4;
    @(negedge clk); #1 reqAddr = 32'h44;
    @(negedge clk); #1 reqAddr = 32'h48;
    @(negedge clk); #1 reqValid = 0;
    @(negedge clk); #1;

    curTag = "R6";
    csrW(0, 32'h40);
    csrW(16, 32'h09);
    acc(32'h80, 4, 0, 0);
    acc(32'h80, 4, 1, 0);
    acc(32'h80, 4, 2, 0);
    acc(32'hfc, 4, 0, 1);

    curTag = "R11";
    acc(32'h100, 4, 0, 0);
    acc(32'h100, 4, 1, 3);
    acc(32'h300, 4, 2, 1);

    curTag = "R10";
    acc(32'h80, 4, 1, 3);
    csrW(16, 32'h89);
    acc(32'h80, 4, 1, 3);
    acc(32'h80, 4, 0, 3);
    csrW(16, 32'h09);

    curTag = "R9";
    acc(32'hfc, 8, 0, 0);
    acc(32'hfc, 8, 0, 3);
    acc(32'hf8, 8, 0, 0);
    acc(32'hfe, 2, 0, 0);

    curTag = "R7";
    csrW(1, 32'h80);
    csrW(2, 32'h41f);
    csrW(16, 32'h001b1109);
    acc(32'h200, 4, 0, 0);
    acc(32'h204, 4, 0, 0);
    acc(32'h1000, 4, 1, 0);
    acc(32'h10fc, 4, 1, 0);
    acc(32'h1100, 4, 1, 0);
    acc(32'hffc, 8, 0, 0);

    curTag = "R8";
    csrW(3, 32'h3f);
    csrW(16, 32'h1f1b1109);
    acc(32'h80, 4, 1, 0);
    acc(32'h180, 4, 1, 0);
    acc(32'hfc, 8, 1, 0);

    curTag = "R6";
    csrW(4, 32'h200);
    csrW(5, 32'h280);
    csrW(17, 32'h00000c00);
    acc(32'h900, 4, 2, 0);
    acc(32'h9fc, 8, 2, 0);
    acc(32'h7fc, 4, 2, 0);

    curTag = "R12";
    acc(32'h5000, 4, 0, 0);
    acc(32'h5004, 4, 1, 1);
    acc(32'h5008, 4, 2, 0);

    curTag = "R5";
    for (int a = 16; a < 20; a++) csrW(a, 0);
    acc(32'h5000, 8, 1, 0);

    curTag = "R7";
    for (int it = 0; it < 3000; it++) begin
      int pick = $urandom_range(0, 5);
      if (pick == 0) csrW($urandom_range(16, 19), $urandom);
      else if (pick == 1) csrW($urandom_range(0, 15), $urandom_range(0, 255));
      else begin
        int pr = $urandom_range(0, 2);
        acc(32'($urandom_range(0, 1023)), $urandom_range(1, 8), $urandom_range(0, 2),
            (pr == 2) ? 3 : pr);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule